// File: doc/BRIEF.md
# Grouped PWM Generator with Locked Synchronous Update

The block drives a set of edge-aligned PWM channels. Each channel has a complementary pair of outputs, and dead time is inserted on each output. Any subset of the channels can be placed in a synchronous group. Members of the group run from channel 0's counter and period, and they are all switched on and off by channel 0's enable bit.

Software never writes a channel's running (active) period, duty or dead-time value directly. Each write lands in a per-channel update register. A channel outside the group copies its update registers into its active values at the end of each of its own periods, with no further action needed. Group channels stay locked. Their active values change only after software sets a single arm bit. The transfer then happens for all group channels in the same cycle, at the next end of channel 0's period, and the arm bit clears itself. Software may then write new values and arm again.

Top module: `pwm_sync_group`

## Requirements
- R1: After reset, every active value, every update register, the group mask, the enable mask and the arm bit read zero, and both outputs of every channel are low.
- R2: Register addresses are as follows. Address 0 is the group mask (bit c marks channel c). Address 1 is the enable mask (bit c). Address 2 bit 0 is the arm bit. Channel c uses addresses 4+4c (period), 5+4c (duty) and 6+4c (dead time). A write to a channel address goes to that update register, and a read of it returns the active value.
- R3: Each enabled channel counts up from 0 to period−1 and restarts at 0. A period of 0 or 1 restarts every cycle. The raw level is high while the count is below the active duty, so duty 0 is always low and duty ≥ period is always high.
- R4: The high output rises a dead-time number of cycles after the raw level rises, and the low output rises the same number of cycles after it falls. A pulse shorter than the dead time never appears on that output. A disabled channel drives both outputs low.
- R5: A group member compares against channel 0's count and follows enable bit 0. Its own enable bit has no effect.
- R6: Writing 1 to arm bit 0 makes it read 1 until channel 0 next ends a period, after which it reads 0. Writing 0 to it has no effect.
- R7: While the arm bit is 0, no group channel's active values change, however many periods pass. On the transfer, all group channels take their update values in the same cycle.
- R8: If an update register is written several times before a transfer, the last value written is the one transferred.
- R9: A channel outside the group loads its update registers at the end of its own period without the arm bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Write address |
| wr_data | input | DW | Write data |
| rd_addr | input | AW | Read address (combinational read) |
| rd_data | output | DW | Read data |
| pwm_hi | output | NCH | High-side output per channel |
| pwm_lo | output | NCH | Low-side output per channel |

## Verification
The hardest situation to reach is an arm bit that stays set over many cycles without transferring. In normal running, channel 0 ends a period within a few cycles and clears the arm bit. The bench disables channel 0 first, so that no period end can occur. It then arms, checks that the bit holds, writes a zero to it, and re-enables channel 0 to release the transfer. Alignment of the group is checked from the ports: in every sampled cycle, the shortest pulse of the group must lie inside the longer ones.

// File: rtl/pwm_sync_pkg.sv
`timescale 1ns/1ps
package pwm_sync_pkg;
  localparam int ADDR_GROUP = 0;
  localparam int ADDR_ENABLE = 1;
  localparam int ADDR_ARM = 2;
  localparam int CH_BASE = 4;
  localparam int CH_STRIDE = 4;

  typedef enum int {FLD_PER = 0, FLD_DUTY = 1, FLD_DEAD = 2} fld_e;

  function automatic int chan_addr(input int c, input fld_e f);
    return CH_BASE + CH_STRIDE * c + int'(f);
  endfunction

  // last count of a period; periods of 0 or 1 restart every cycle
  function automatic logic period_end(input logic [31:0] cnt, input logic [31:0] per);
    return (per <= 32'd1) || (cnt >= per - 32'd1);
  endfunction

  function automatic logic duty_level(input logic [31:0] cnt, input logic [31:0] duty);
    return cnt < duty;
  endfunction
endpackage

// File: rtl/pwm_chan.sv
`timescale 1ns/1ps
module pwm_chan
  import pwm_sync_pkg::*;
#(
  parameter int CW  = 16,
  parameter int DTW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en,
  input  logic           use_ext,
  input  logic [CW-1:0]  ext_cnt,
  input  logic [CW-1:0]  per,
  input  logic [CW-1:0]  duty,
  input  logic [DTW-1:0] dead,
  output logic [CW-1:0]  cnt,
  output logic           wrap,
  output logic           raw,
  output logic           hi,
  output logic           lo
);
  localparam logic [DTW-1:0] RUN_MAX = '1;

  logic [CW-1:0]  cnt_q;
  logic [CW-1:0]  cmp_cnt;
  logic [DTW-1:0] hrun_q, lrun_q;

  assign cnt     = cnt_q;
  assign wrap    = en && period_end(32'(cnt_q), 32'(per));
  assign cmp_cnt = use_ext ? ext_cnt : cnt_q;
  assign raw     = en && duty_level(32'(cmp_cnt), 32'(duty));
  assign hi      = raw && (hrun_q >= dead);
  assign lo      = en && !raw && (lrun_q >= dead);

  always_ff @(posedge clk) begin
    if (!rst_n || !en)  cnt_q <= '0;
    else if (wrap)      cnt_q <= '0;
    else                cnt_q <= cnt_q + 1'b1;
  end

  // cycles the raw level has held, saturating
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hrun_q <= '0;
      lrun_q <= '0;
    end else begin
      hrun_q <= raw ? ((hrun_q == RUN_MAX) ? hrun_q : hrun_q + 1'b1) : '0;
      lrun_q <= (en && !raw) ? ((lrun_q == RUN_MAX) ? lrun_q : lrun_q + 1'b1) : '0;
    end
  end

  AST_WRAP_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (cnt_q == '0)); // R3
  AST_HI_DELAYED: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(hi) && dead != '0) |-> $past(raw)); // R4
  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (!hi && !lo)); // R4
  AST_PAIR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(hi && lo)); // R4
endmodule

// File: rtl/pwm_regs.sv
`timescale 1ns/1ps
module pwm_regs
  import pwm_sync_pkg::*;
#(
  parameter int NCH = 4,
  parameter int AW  = 5,
  parameter int DW  = 16,
  parameter int CW  = 16,
  parameter int DTW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [AW-1:0]  wr_addr,
  input  logic [DW-1:0]  wr_data,
  input  logic [AW-1:0]  rd_addr,
  input  logic [NCH-1:0] wrap,
  output logic [DW-1:0]  rd_data,
  output logic [NCH-1:0] grp_q,
  output logic [NCH-1:0] en_q,
  output logic           armed,
  output logic           commit,
  output logic [CW-1:0]  act_per  [NCH],
  output logic [CW-1:0]  act_duty [NCH],
  output logic [DTW-1:0] act_dead [NCH]
);
  logic arm_wr;
  logic [NCH-1:0] load;

  assign arm_wr = wr_en && (wr_addr == AW'(ADDR_ARM)) && wr_data[0];
  assign commit = armed && wrap[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      grp_q <= '0;
      en_q  <= '0;
      armed <= 1'b0;
    end else begin
      if (wr_en && wr_addr == AW'(ADDR_GROUP))  grp_q <= wr_data[NCH-1:0];
      if (wr_en && wr_addr == AW'(ADDR_ENABLE)) en_q  <= wr_data[NCH-1:0];
      if (arm_wr)      armed <= 1'b1;
      else if (commit) armed <= 1'b0;
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [CW-1:0]  upd_per, upd_duty;
    logic [DTW-1:0] upd_dead;

    assign load[c] = grp_q[c] ? commit : wrap[c];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        upd_per  <= '0;
        upd_duty <= '0;
        upd_dead <= '0;
        act_per[c]  <= '0;
        act_duty[c] <= '0;
        act_dead[c] <= '0;
      end else begin
        if (wr_en && wr_addr == AW'(chan_addr(c, FLD_PER)))  upd_per  <= wr_data[CW-1:0];
        if (wr_en && wr_addr == AW'(chan_addr(c, FLD_DUTY))) upd_duty <= wr_data[CW-1:0];
        if (wr_en && wr_addr == AW'(chan_addr(c, FLD_DEAD))) upd_dead <= wr_data[DTW-1:0];
        if (load[c]) begin
          act_per[c]  <= upd_per;
          act_duty[c] <= upd_duty;
          act_dead[c] <= upd_dead;
        end
      end
    end

    AST_GROUP_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      (grp_q[c] && !armed) |=> ($stable(act_duty[c]) && $stable(act_per[c]))); // R7
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr == AW'(ADDR_GROUP))  rd_data = DW'(grp_q);
    if (rd_addr == AW'(ADDR_ENABLE)) rd_data = DW'(en_q);
    if (rd_addr == AW'(ADDR_ARM))    rd_data = DW'(armed);
    for (int c = 0; c < NCH; c++) begin
      if (rd_addr == AW'(chan_addr(c, FLD_PER)))  rd_data = DW'(act_per[c]);
      if (rd_addr == AW'(chan_addr(c, FLD_DUTY))) rd_data = DW'(act_duty[c]);
      if (rd_addr == AW'(chan_addr(c, FLD_DEAD))) rd_data = DW'(act_dead[c]);
    end
  end

  AST_ARM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !wrap[0]) |=> armed); // R6
  AST_ARM_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !arm_wr) |=> !armed); // R6
endmodule

// File: rtl/pwm_sync_group.sv
`timescale 1ns/1ps
module pwm_sync_group
  import pwm_sync_pkg::*;
#(
  parameter int NCH = 4,
  parameter int DW  = 16,
  parameter int CW  = 16,
  parameter int DTW = 8,
  parameter int AW  = $clog2(CH_BASE + CH_STRIDE * NCH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [AW-1:0]  wr_addr,
  input  logic [DW-1:0]  wr_data,
  input  logic [AW-1:0]  rd_addr,
  output logic [DW-1:0]  rd_data,
  output logic [NCH-1:0] pwm_hi,
  output logic [NCH-1:0] pwm_lo
);
  logic [NCH-1:0] grp_q, en_q, eff_en, wrap, raw;
  logic           armed, commit;
  logic [CW-1:0]  act_per  [NCH];
  logic [CW-1:0]  act_duty [NCH];
  logic [DTW-1:0] act_dead [NCH];
  logic [CW-1:0]  cnt      [NCH];

  pwm_regs #(.NCH(NCH), .AW(AW), .DW(DW), .CW(CW), .DTW(DTW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .wrap(wrap), .rd_data(rd_data), .grp_q(grp_q), .en_q(en_q),
    .armed(armed), .commit(commit), .act_per(act_per), .act_duty(act_duty),
    .act_dead(act_dead)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign eff_en[c] = grp_q[c] ? en_q[0] : en_q[c];

    pwm_chan #(.CW(CW), .DTW(DTW)) u_chan (
      .clk(clk), .rst_n(rst_n), .en(eff_en[c]), .use_ext(grp_q[c]), .ext_cnt(cnt[0]),
      .per(act_per[c]), .duty(act_duty[c]), .dead(act_dead[c]), .cnt(cnt[c]),
      .wrap(wrap[c]), .raw(raw[c]), .hi(pwm_hi[c]), .lo(pwm_lo[c])
    );

    AST_MEMBER_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      (grp_q[c] && grp_q[0] && act_duty[c] == act_duty[0]) |-> (raw[c] == raw[0])); // R5
  end

  AST_COMMIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> armed); // R7
endmodule

// File: tb/test_pwm_sync_group.sv
`timescale 1ns/1ps
module test_pwm_sync_group;
  localparam int NCH = 4;
  localparam int AW  = 5;
  localparam int DW  = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [AW-1:0] rd_addr = '0;
  logic [DW-1:0] rd_data;
  logic [NCH-1:0] pwm_hi, pwm_lo;

  int checks = 0;
  int fails = 0;
  int hc [NCH];
  int lc [NCH];
  int misalign;

  always #10 clk = ~clk;

  pwm_sync_group i_pwm_sync_group (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .pwm_hi(pwm_hi), .pwm_lo(pwm_lo)
  );

  // period, duty, dead, expected high cycles, expected low cycles per period
  localparam int VEC [0:6][0:4] = '{
    '{10, 4, 1, 3, 5},
    '{10, 4, 0, 4, 6},
    '{12, 0, 2, 0, 12},
    '{ 8, 8, 3, 8, 0},
    '{16, 3, 5, 0, 8},
    '{20, 15, 6, 9, 0},
    '{ 9, 20, 0, 9, 0}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = AW'(a); wr_data = DW'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output int v);
    rd_addr = AW'(a);
    #1 v = int'(rd_data);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic count(input int n);
    for (int c = 0; c < NCH; c++) begin hc[c] = 0; lc[c] = 0; end
    misalign = 0;
    repeat (n) begin
      @(negedge clk);
      #1;
      for (int c = 0; c < NCH; c++) begin
        hc[c] += int'(pwm_hi[c]);
        lc[c] += int'(pwm_lo[c]);
      end
      if (pwm_hi[2] && !(pwm_hi[0] && pwm_hi[3])) misalign++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int v;
    idle(5);
    rst_n = 1'b1;
    idle(2);
    // R1 reset state
    for (int a = 0; a < 20; a++) begin
      rd(a, v);
      chk($sformatf("R1 addr %0d", a), v, 0);
    end
    #1 chk("R1 outputs", int'({pwm_hi, pwm_lo}), 0);

    // R2 R3 R4 R9: channel 1 outside the group, no arming
    wr(1, 2);
    for (int i = 0; i < 7; i++) begin
      wr(8, VEC[i][0]);
      wr(9, VEC[i][1]);
      wr(10, VEC[i][2]);
      idle(45);
      rd(8, v);  chk($sformatf("R9 vec%0d period loaded", i), v, VEC[i][0]);
      rd(10, v); chk($sformatf("R2 vec%0d dead readback", i), v, VEC[i][2]);
      rd(2, v);  chk($sformatf("R9 vec%0d arm untouched", i), v, 0);
      count(VEC[i][0]);
      chk($sformatf("R3 R4 vec%0d high cycles", i), hc[1], VEC[i][3]);
      chk($sformatf("R3 R4 vec%0d low cycles", i), lc[1], VEC[i][4]);
    end
    wr(1, 0);
    idle(2);
    count(10);
    chk("R4 disabled high", hc[1], 0);
    chk("R4 disabled low", lc[1], 0);

    // R5 R7: group {0,2,3}, enable only bit 0
    wr(0, 13);
    wr(4, 10); wr(5, 5); wr(6, 0);
    wr(12, 10); wr(13, 2);
    wr(16, 10); wr(17, 7);
    wr(1, 1);
    idle(40);
    rd(4, v);  chk("R7 locked period ch0", v, 0);
    rd(13, v); chk("R7 locked duty ch2", v, 0);
    count(10);
    chk("R7 locked ch2 silent", hc[2], 0);

    wr(2, 1);
    rd(2, v);  chk("R6 arm reads one", v, 1);
    idle(3);
    rd(2, v);  chk("R6 arm self clears", v, 0);
    rd(4, v);  chk("R7 ch0 period moved", v, 10);
    rd(13, v); chk("R7 ch2 duty moved", v, 2);
    rd(17, v); chk("R7 ch3 duty moved", v, 7);
    count(20);
    chk("R5 ch0 high", hc[0], 10);
    chk("R5 ch2 high via ch0 enable", hc[2], 4);
    chk("R5 ch3 high", hc[3], 14);
    chk("R7 group aligned", misalign, 0);

    // R8 last write wins
    wr(5, 1); wr(5, 8);
    idle(30);
    rd(5, v); chk("R7 duty held while unarmed", v, 5);
    wr(2, 1);
    rd(2, v); chk("R6 second arm", v, 1);
    idle(12);
    rd(2, v); chk("R6 second clear", v, 0);
    rd(5, v); chk("R8 last value", v, 8);
    count(10);
    chk("R8 ch0 high", hc[0], 8);

    // R6 arm held with no period end; zero write ignored
    wr(1, 0);
    idle(3);
    #1 chk("R5 group off with ch0", int'(pwm_hi | pwm_lo), 0);
    wr(2, 1);
    idle(20);
    rd(2, v); chk("R6 held without period end", v, 1);
    wr(2, 0);
    rd(2, v); chk("R6 zero write ignored", v, 1);
    wr(1, 1);
    idle(12);
    rd(2, v); chk("R6 cleared after restart", v, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule